// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the bank of 32-bit control words that a north bridge exposes to its processor. Software reaches it through a plain memory-mapped port: an address, a write strobe, write data and a combinational read-data bus. The window starts at byte offset 0x100 of the bridge register space and holds 28 words, so its last word sits at 0x16C. Most words are plain storage for configuration, GPIO, interrupt routing, mailbox, cache and timing settings. The functions behind those settings live elsewhere and are not part of this block.

Two words behave differently. The interrupt enable word cannot be written directly. Software sets bits in it through a set alias and clears bits through a clear alias. Each alias also keeps the last value written to it. The general configuration word drives a one-cycle software reset request, but only when one of its bits goes from 0 to 1. The port has no back-pressure. A write is taken on the clock edge at which the write strobe is high, and a read is answered in the same cycle. For this reason the access port is kept as plain control pins and not as a valid/ready stream.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: After reset the words read as follows: 0x100 = 0x00000C40, 0x104 = 0x00001384, 0x108 = 0x2BFF8010, 0x10C = 0x255E0091, 0x110 = 0x00006140, 0x11C = 0x000001FF, 0x120 = 0x000001FF, 0x168 = 0x00000008, 0x16C = 0x10000000. Every other word reads zero, and the reset request is low.
- R2: A write to a plain storage word is taken at the clock edge where acc_wr is high. From the next cycle on, a read of that word returns the written value. Read data is combinational from acc_addr, with no added cycle.
- R3: A write to the set alias at 0x130 stores the value, which reads back at 0x130. It also ORs the written bits into the enable word at 0x138.
- R4: A write to the clear alias at 0x134 stores the value, which reads back at 0x134. It also clears the written bits in the enable word at 0x138 and leaves the other bits unchanged.
- R5: Direct writes to the enable word at 0x138 and to the interrupt status word at 0x13C are ignored. The status word always reads zero, and the enable word changes only through the two aliases.
- R6: A write to 0x104 whose bit 2 is 1, when the stored bit 2 is 0, raises soft_rst_req for exactly the one cycle after the write edge. The written value is stored in full.
- R7: A write to 0x104 raises no reset request when the stored bit 2 is already 1 or the written bit 2 is 0. The value is still stored.
- R8: A write is ignored when its address lies outside 0x100 to 0x16F or is not word-aligned (acc_addr[1:0] not zero). A read at such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 12 | Byte address within the bridge register space |
| acc_wr | input | 1 | Write strobe; a full 32-bit write is taken at the edge where it is high |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, combinational |
| soft_rst_req | output | 1 | One-cycle software reset request |

## Verification
A wrong decode or a wrong write-enable shows up as a corrupted or missing value at the very next read. This is because read data is combinational and every write lands in one edge. An error in the enable word can be hidden behind the aliases, so it is exposed by reading 0x138 after each set, clear and direct write, using bit patterns that overlap. An edge detector that looks at the written value alone, or at the stored bit after the update, fires on the wrong writes. It is caught by writing 0x104 with bit 2 held high, then dropped, then raised again, and sampling soft_rst_req one cycle after each write edge.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int HBR_WORDS    = 28;
  localparam int IDX_PWRON    = 0;
  localparam int IDX_GENCFG   = 1;
  localparam int IDX_IODEV    = 2;
  localparam int IDX_DRAMCFG  = 3;
  localparam int IDX_WINMAP   = 4;
  localparam int IDX_GPIO_DAT = 7;
  localparam int IDX_GPIO_DIR = 8;
  localparam int IDX_EN_SET   = 12;
  localparam int IDX_EN_CLR   = 13;
  localparam int IDX_EN       = 14;
  localparam int IDX_ISR      = 15;
  localparam int IDX_DQ       = 26;
  localparam int IDX_MEMSZ    = 27;
  localparam int GEN_RST_BIT  = 2;

  function automatic logic [31:0] hbr_rst_val(input int idx);
    case (idx)
      IDX_PWRON:    return 32'h0000_0C40;
      IDX_GENCFG:   return 32'h0000_1384;
      IDX_IODEV:    return 32'h2BFF_8010;
      IDX_DRAMCFG:  return 32'h255E_0091;
      IDX_WINMAP:   return 32'h0000_6140;
      IDX_GPIO_DAT: return 32'h0000_01FF;
      IDX_GPIO_DIR: return 32'h0000_01FF;
      IDX_DQ:       return 32'h0000_0008;
      IDX_MEMSZ:    return 32'h1000_0000;
      default:      return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/hbr_addr_dec.sv
module hbr_addr_dec #(
  parameter int ADDR_W    = 12,
  parameter int WIN_BASE  = 'h100,
  parameter int NUM_WORDS = 28,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN_END = WIN_BASE + 4 * NUM_WORDS;

  logic [ADDR_W-1:0] offs;
  logic              above, below;

  assign offs  = addr - ADDR_W'(WIN_BASE);
  assign above = ({1'b0, addr} >= (ADDR_W+1)'(WIN_BASE));
  assign below = ({1'b0, addr} <  (ADDR_W+1)'(WIN_END));
  assign hit   = above && below && (addr[1:0] == 2'b00);
  assign idx   = offs[IDX_W+1:2];
endmodule

// File: rtl/hbr_inten_unit.sv
module hbr_inten_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (set_we) en <= en | wdata;
    else if (clr_we) en <= en & ~wdata;
  end

  // R3
  en_set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en & $past(wdata)) == $past(wdata)));
  // R4
  en_clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en & $past(wdata)) == '0));
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/hbr_reg_array.sv
module hbr_reg_array
  import hbr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = HBR_WORDS,
  parameter int IDX_W     = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [DATA_W-1:0]                en_val,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] words
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == IDX_EN) begin : g_en
      assign words[i] = en_val;
    end else if (i == IDX_ISR) begin : g_isr
      assign words[i] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                         q <= DATA_W'(hbr_rst_val(i));
        else if (we && idx == IDX_W'(i))    q <= wdata;
      end
      assign words[i] = q;
    end
  end
endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs
  import hbr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int WIN_BASE  = 'h100,
  parameter int NUM_WORDS = HBR_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              soft_rst_req
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic                             hit;
  logic [IDX_W-1:0]                 idx;
  logic                             wr_hit, set_we, clr_we, gen_we, gen_rise;
  logic [DATA_W-1:0]                en_val;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;

  hbr_addr_dec #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(acc_addr), .hit(hit), .idx(idx)
  );

  assign wr_hit = acc_wr && hit;
  assign set_we = wr_hit && (idx == IDX_W'(IDX_EN_SET));
  assign clr_we = wr_hit && (idx == IDX_W'(IDX_EN_CLR));
  assign gen_we = wr_hit && (idx == IDX_W'(IDX_GENCFG));

  hbr_inten_unit #(.DATA_W(DATA_W)) u_inten (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(acc_wdata), .en(en_val)
  );

  hbr_reg_array #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(wr_hit), .idx(idx), .wdata(acc_wdata),
    .en_val(en_val), .words(words)
  );

  assign gen_rise = gen_we && !words[IDX_GENCFG][GEN_RST_BIT]
                    && acc_wdata[GEN_RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) soft_rst_req <= 1'b0;
    else        soft_rst_req <= gen_rise;
  end

  assign acc_rdata = hit ? words[idx] : '0;

  // R6
  rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> !soft_rst_req);
  // R7
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(gen_we) && !$past(words[IDX_GENCFG][GEN_RST_BIT]));
  // R8
  stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !hit) |=> $stable(words));
  // R5
  isr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    words[IDX_ISR] == '0);
endmodule

// File: tb/hbr_ctrl_regs_bench.sv
`timescale 1ns/1ps
module hbr_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        soft_rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic pulse_seen;

  always #4 clk = ~clk;

  hbr_ctrl_regs u_hbr_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .soft_rst_req(soft_rst_req)
  );

  // {address, write data}; read-back equals write data (R2)
  localparam logic [43:0] VEC [8] = '{
    {12'h100, 32'hA5A5_0001}, {12'h108, 32'h1234_5678},
    {12'h118, 32'h0001_FFFF}, {12'h124, 32'hFFFF_0000},
    {12'h140, 32'hCAFE_F00D}, {12'h14C, 32'h0BAD_BEEF},
    {12'h15C, 32'h8000_0001}, {12'h16C, 32'h2000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
    pulse_seen = soft_rst_req;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    acc_addr = a;
    #1;
    check(req, acc_rdata, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 req", {31'b0, soft_rst_req}, 32'h0);
    rd_chk("R1", 12'h100, 32'h0000_0C40);
    rd_chk("R1", 12'h104, 32'h0000_1384);
    rd_chk("R1", 12'h108, 32'h2BFF_8010);
    rd_chk("R1", 12'h10C, 32'h255E_0091);
    rd_chk("R1", 12'h110, 32'h0000_6140);
    rd_chk("R1", 12'h11C, 32'h0000_01FF);
    rd_chk("R1", 12'h120, 32'h0000_01FF);
    rd_chk("R1", 12'h168, 32'h0000_0008);
    rd_chk("R1", 12'h16C, 32'h1000_0000);
    rd_chk("R1", 12'h138, 32'h0);
    rd_chk("R1", 12'h144, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][43:32], VEC[i][31:0]);
      rd_chk("R2", VEC[i][43:32], VEC[i][31:0]);
    end

    wr(12'h130, 32'h0000_00F0);
    rd_chk("R3", 12'h138, 32'h0000_00F0);
    wr(12'h130, 32'h0F00_0003);
    rd_chk("R3", 12'h138, 32'h0F00_00F3);
    rd_chk("R3", 12'h130, 32'h0F00_0003);
    wr(12'h134, 32'h0000_0030);
    rd_chk("R4", 12'h138, 32'h0F00_00C3);
    rd_chk("R4", 12'h134, 32'h0000_0030);

    wr(12'h138, 32'hFFFF_FFFF);
    rd_chk("R5", 12'h138, 32'h0F00_00C3);
    wr(12'h13C, 32'h0000_FFFF);
    rd_chk("R5", 12'h13C, 32'h0);

    wr(12'h104, 32'h0000_1384);
    check("R7 held", {31'b0, pulse_seen}, 32'h0);
    wr(12'h104, 32'h0000_1380);
    check("R7 drop", {31'b0, pulse_seen}, 32'h0);
    rd_chk("R7", 12'h104, 32'h0000_1380);
    wr(12'h104, 32'h0000_1384);
    check("R6 rise", {31'b0, pulse_seen}, 32'h1);
    @(negedge clk);
    check("R6 width", {31'b0, soft_rst_req}, 32'h0);
    rd_chk("R6", 12'h104, 32'h0000_1384);

    wr(12'h102, 32'hDEAD_DEAD);
    rd_chk("R8 misaligned", 12'h100, 32'hA5A5_0001);
    rd_chk("R8 misaligned rd", 12'h102, 32'h0);
    wr(12'h170, 32'h1111_1111);
    rd_chk("R8 above", 12'h170, 32'h0);
    rd_chk("R8 above alias", 12'h100, 32'hA5A5_0001);
    wr(12'h0FC, 32'h2222_2222);
    rd_chk("R8 below", 12'h0FC, 32'h0);
    rd_chk("R8 below alias", 12'h16C, 32'h2000_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule